// File: doc/BRIEF.md
# ECC Dual-Port RAM Collision Guard

This block is a true dual-port RAM on one clock. Each stored word carries an extended Hamming check field. Two ports, A and B, each have an enable, a write enable, an address and write data. A read returns the decoded word one cycle after its request. In the same cycle the block returns a read-valid qualifier and the single-correct and double-detect flags.

On every clock edge a small tracker looks at both requests and records whether the two ports meet at one address, and in which way. A read that meets a write from the other port, or a port caught in a write-write conflict, comes back marked not valid. The ECC flags of that read are forced low. Consumers drop such a read instead of stalling. The RAM read itself is never gated by the guard. When both ports read the same word, both reads stay valid. When both ports write the same word, a conflict flag is raised and port A's word is kept.

Each port also has a two-bit fault-injection field that corrupts the stored check word on a write. This lets the correcting and detecting paths be exercised through the normal ports.

Top module: `dpram_ecc_guard`

The tracker holds one registered state per cycle. The state is shown on `coll_code`:

- IDLE (0): no collision.
- BOTH_READ (1): both ports read the same address.
- A_WR_B_RD (2): A writes and B reads the same address.
- B_WR_A_RD (3): B writes and A reads the same address.
- BOTH_WRITE (4): both ports write the same address.

Each edge moves the state to the value classified from that cycle's requests. Any state can move to any other state. Reset forces IDLE.

## Requirements
- R1: While reset is low (asynchronous, active low), `a_rvalid`, `b_rvalid`, `a_corr`, `a_dbl`, `b_corr`, `b_dbl` and `ww_conflict` are 0, and `coll_code` is 0.
- R2: A read with en=1 and we=0 shows the last word written to that address on `x_rdata`, with `x_rvalid`=1, in the cycle after the request.
- R3: A collision exists only when both enables are 1 and the addresses are equal. `coll_code` shows the class one cycle later: 0 none, 1 both read, 2 A writes/B reads, 3 B writes/A reads, 4 both write.
- R4: When both ports read the same address, both reads are valid and return the stored word.
- R5: In a read/write collision, the reading port's `x_rvalid` is 0 and its corrected and detected flags are 0, even when the stored word holds an error.
- R6: The write in a read/write collision stores the data and check bits correctly, so a later read of that address returns the new word with no ECC flag.
- R7: When both ports write the same address, `ww_conflict` is 1 in the next cycle, both `x_rvalid` are 0, and port A's word is the one stored.
- R8: A write with `x_inj`=01 (flips codeword bit 3) or 10 (flips codeword bit 5) is later read back as the original data, with `x_corr`=1 and `x_dbl`=0.
- R9: A write with `x_inj`=11 (flips both bits) is later read with `x_dbl`=1 and `x_corr`=0.
- R10: A port that writes, or is disabled, shows `x_rvalid`=0. `x_corr` and `x_dbl` are never 1 while `x_rvalid` is 0.
- R11: The RAM read is not gated by the guard. With the default read-first mode, a read that collides with a write still presents the word held before that write on `x_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| a_inj | input | 2 | Port A fault injection on write |
| a_rdata | output | DATA_W | Port A corrected read data |
| a_rvalid | output | 1 | Port A read qualifier |
| a_corr | output | 1 | Port A single-bit corrected |
| a_dbl | output | 1 | Port A double-bit detected |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| b_inj | input | 2 | Port B fault injection on write |
| b_rdata | output | DATA_W | Port B corrected read data |
| b_rvalid | output | 1 | Port B read qualifier |
| b_corr | output | 1 | Port B single-bit corrected |
| b_dbl | output | 1 | Port B double-bit detected |
| ww_conflict | output | 1 | Both ports wrote the same address last cycle |
| coll_code | output | 3 | Registered collision class |

## Verification
The collision logic is driven with several patterns:

- Reads at distinct addresses.
- Reads at one shared address.
- A write and a read crossing in each direction.
- Two writes at one address.
- Equal addresses with one port disabled, which must not count as a collision.

Together these separate a missing classification from a wrong one, and a masked read from an ungated one.

A read-back follows each collision. It shows whether the write committed and which port won.

The ECC patterns inject single flips at two bit positions and a double flip. One double-flipped word is then read during a collision, which shows that the flag masking overrides real error detection.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;

    typedef enum logic [2:0] {
        CL_IDLE       = 3'd0,
        CL_BOTH_READ  = 3'd1,
        CL_A_WR_B_RD  = 3'd2,
        CL_B_WR_A_RD  = 3'd3,
        CL_BOTH_WRITE = 3'd4
    } coll_state_e;

    typedef enum int {
        MODE_READ_FIRST  = 0,
        MODE_WRITE_FIRST = 1,
        MODE_NO_CHANGE   = 2
    } wr_mode_e;

    // number of Hamming check bits for k data bits
    function automatic int ecc_pbits(input int k);
        int p;
        p = 0;
        while ((1 << p) < (k + p + 1)) p++;
        return p;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import ecc_guard_pkg::*;
#(
    parameter int DW = 16,
    localparam int PW = ecc_pbits(DW),
    localparam int N  = DW + PW,
    localparam int CW = N + 1
) (
    input  logic [DW-1:0] data,
    output logic [CW-1:0] code
);

    always_comb begin
        logic [CW-1:0] c;
        int            j;
        logic          p;
        c = '0;
        j = 0;
        // place data bits at positions that are not powers of two
        for (int pos = 1; pos <= N; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                c[pos] = data[j];
                j++;
            end
        end
        for (int i = 0; i < PW; i++) begin
            p = 1'b0;
            for (int pos = 1; pos <= N; pos++) begin
                if ((pos & (1 << i)) != 0) p = p ^ c[pos];
            end
            c[1 << i] = p;
        end
        c[0] = ^c[N:1];
        code = c;
    end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import ecc_guard_pkg::*;
#(
    parameter int DW = 16,
    localparam int PW = ecc_pbits(DW),
    localparam int N  = DW + PW,
    localparam int CW = N + 1
) (
    input  logic [CW-1:0] code,
    output logic [DW-1:0] data,
    output logic          single_err,
    output logic          double_err
);

    always_comb begin
        logic [PW-1:0] syn;
        logic          odd;
        logic [CW-1:0] fixed;
        int            j;
        syn = '0;
        for (int pos = 1; pos <= N; pos++) begin
            if (code[pos]) syn = syn ^ PW'(pos);
        end
        odd   = ^code;
        fixed = code;
        single_err = odd;
        double_err = !odd && (syn != '0);
        if (odd && (syn != '0) && (int'(syn) <= N)) fixed[syn] = ~code[syn];
        j = 0;
        data = '0;
        for (int pos = 1; pos <= N; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                data[j] = fixed[pos];
                j++;
            end
        end
    end

endmodule

// File: rtl/dp_store.sv
module dp_store
    import ecc_guard_pkg::*;
#(
    parameter int CW   = 22,
    parameter int AW   = 4,
    parameter int MODE = MODE_READ_FIRST,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [CW-1:0] a_wcode,
    output logic [CW-1:0] a_rcode,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [CW-1:0] b_wcode,
    output logic [CW-1:0] b_rcode
);

    logic [CW-1:0] mem [DEPTH];

    // port B is written first so that port A wins a same-address clash
    always_ff @(posedge clk) begin
        if (b_en && b_we) mem[b_addr] <= b_wcode;
        if (a_en && a_we) mem[a_addr] <= a_wcode;
    end

    generate
        if (MODE == MODE_WRITE_FIRST) begin : g_wf
            always_ff @(posedge clk) begin
                if (a_en) a_rcode <= a_we ? a_wcode : mem[a_addr];
                if (b_en) b_rcode <= b_we ? b_wcode : mem[b_addr];
            end
        end else if (MODE == MODE_NO_CHANGE) begin : g_nc
            always_ff @(posedge clk) begin
                if (a_en && !a_we) a_rcode <= mem[a_addr];
                if (b_en && !b_we) b_rcode <= mem[b_addr];
            end
        end else begin : g_rf
            always_ff @(posedge clk) begin
                if (a_en) a_rcode <= mem[a_addr];
                if (b_en) b_rcode <= mem[b_addr];
            end
        end
    endgenerate

endmodule

// File: rtl/collision_tracker.sv
module collision_tracker
    import ecc_guard_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    output coll_state_e   state,
    output logic          a_ok,
    output logic          b_ok,
    output logic          ww_flag
);

    coll_state_e next_state;
    logic        a_rd_q, b_rd_q;
    logic        meet;

    always_comb begin
        meet = a_en && b_en && (a_addr == b_addr);
        next_state = CL_IDLE;
        if (meet) begin
            unique case ({a_we, b_we})
                2'b00:   next_state = CL_BOTH_READ;
                2'b10:   next_state = CL_A_WR_B_RD;
                2'b01:   next_state = CL_B_WR_A_RD;
                default: next_state = CL_BOTH_WRITE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= CL_IDLE;
            a_rd_q <= 1'b0;
            b_rd_q <= 1'b0;
        end else begin
            state  <= next_state;
            a_rd_q <= a_en && !a_we;
            b_rd_q <= b_en && !b_we;
        end
    end

    always_comb begin
        a_ok    = 1'b0;
        b_ok    = 1'b0;
        ww_flag = 1'b0;
        unique case (state)
            CL_IDLE, CL_BOTH_READ: begin
                a_ok = a_rd_q;
                b_ok = b_rd_q;
            end
            CL_A_WR_B_RD: begin
                a_ok = 1'b0;
                b_ok = 1'b0;
            end
            CL_B_WR_A_RD: begin
                a_ok = 1'b0;
                b_ok = 1'b0;
            end
            CL_BOTH_WRITE: ww_flag = 1'b1;
            default: ;
        endcase
    end

    // R4: a same-address read pair keeps both reads valid
    a_r4_both_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && b_en && !a_we && !b_we && a_addr == b_addr) |=> (a_ok && b_ok));

    // R5: the reading side of a crossing is never qualified
    a_r5_cross_read_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && b_en && (a_we != b_we) && a_addr == b_addr) |=> (!a_ok && !b_ok));

    // R7: a same-address write pair raises the conflict flag
    a_r7_ww_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && b_en && a_we && b_we && a_addr == b_addr) |=> ww_flag);

endmodule

// File: rtl/dpram_ecc_guard.sv
module dpram_ecc_guard
    import ecc_guard_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter int WMODE  = MODE_READ_FIRST,
    localparam int CW    = DATA_W + ecc_pbits(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic [1:0]        a_inj,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_rvalid,
    output logic              a_corr,
    output logic              a_dbl,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic [1:0]        b_inj,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_rvalid,
    output logic              b_corr,
    output logic              b_dbl,
    output logic              ww_conflict,
    output logic [2:0]        coll_code
);

    logic [CW-1:0] a_enc, b_enc, a_wcode, b_wcode, a_rcode, b_rcode;
    logic          a_sgl, a_dbe, b_sgl, b_dbe;
    coll_state_e   st;

    secded_enc #(.DW(DATA_W)) u_enc_a (.data(a_wdata), .code(a_enc));
    secded_enc #(.DW(DATA_W)) u_enc_b (.data(b_wdata), .code(b_enc));

    // fault injection: bit 0 flips codeword bit 3, bit 1 flips codeword bit 5
    assign a_wcode = a_enc ^ ((CW'(a_inj[0]) << 3) | (CW'(a_inj[1]) << 5));
    assign b_wcode = b_enc ^ ((CW'(b_inj[0]) << 3) | (CW'(b_inj[1]) << 5));

    dp_store #(.CW(CW), .AW(ADDR_W), .MODE(WMODE)) u_store (
        .clk(clk),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wcode(a_wcode), .a_rcode(a_rcode),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wcode(b_wcode), .b_rcode(b_rcode)
    );

    collision_tracker #(.AW(ADDR_W)) u_track (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr),
        .state(st), .a_ok(a_rvalid), .b_ok(b_rvalid), .ww_flag(ww_conflict)
    );

    secded_dec #(.DW(DATA_W)) u_dec_a (.code(a_rcode), .data(a_rdata),
                                       .single_err(a_sgl), .double_err(a_dbe));
    secded_dec #(.DW(DATA_W)) u_dec_b (.code(b_rcode), .data(b_rdata),
                                       .single_err(b_sgl), .double_err(b_dbe));

    assign a_corr    = a_rvalid && a_sgl;
    assign a_dbl     = a_rvalid && a_dbe;
    assign b_corr    = b_rvalid && b_sgl;
    assign b_dbl     = b_rvalid && b_dbe;
    assign coll_code = st;

    // R10: flags never stand without a valid read
    a_r10_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_corr || a_dbl) |-> a_rvalid) and ((b_corr || b_dbl) |-> b_rvalid));

    // R9: corrected and detected are exclusive
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_corr && a_dbl) && !(b_corr && b_dbl));

    // R7: a write-write conflict leaves no valid read
    a_r7_conflict_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        ww_conflict |-> (!a_rvalid && !b_rvalid));

    // R10: a write request never yields a valid read next cycle
    a_r10_write_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_we) |=> !a_rvalid);

endmodule

// File: tb/dpram_ecc_guard_test.sv
module dpram_ecc_guard_test;

    typedef struct packed {
        logic        en;
        logic        we;
        logic [3:0]  addr;
        logic [15:0] data;
        logic [1:0]  inj;
    } op_t;

    typedef struct packed {
        logic        v;
        logic        chk;
        logic [15:0] data;
        logic        corr;
        logic        dbl;
    } exp_t;

    typedef struct packed {
        op_t        a;
        op_t        b;
        exp_t       ea;
        exp_t       eb;
        logic       ww;
        logic [2:0] code;
    } vec_t;

    localparam op_t  NOP = '{1'b0, 1'b0, 4'd0, 16'h0, 2'b00};
    localparam exp_t NX  = '{1'b0, 1'b0, 16'h0, 1'b0, 1'b0};

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        // 0: writes at distinct addresses (R10)
        '{'{1,1,4'd1,16'h1111,2'b00}, '{1,1,4'd2,16'h2222,2'b00}, NX, NX, 1'b0, 3'd0},
        // 1: seed address 3
        '{'{1,1,4'd3,16'h0303,2'b00}, NOP, NX, NX, 1'b0, 3'd0},
        // 2: distinct reads (R2)
        '{'{1,0,4'd1,16'h0,2'b00}, '{1,0,4'd2,16'h0,2'b00},
          '{1,1,16'h1111,0,0}, '{1,1,16'h2222,0,0}, 1'b0, 3'd0},
        // 3: both read address 2 (R4)
        '{'{1,0,4'd2,16'h0,2'b00}, '{1,0,4'd2,16'h0,2'b00},
          '{1,1,16'h2222,0,0}, '{1,1,16'h2222,0,0}, 1'b0, 3'd1},
        // 4: A writes, B reads address 3 (R5, R11 old word)
        '{'{1,1,4'd3,16'h3333,2'b00}, '{1,0,4'd3,16'h0,2'b00},
          NX, '{0,1,16'h0303,0,0}, 1'b0, 3'd2},
        // 5: read back address 3 (R6)
        '{'{1,0,4'd3,16'h0,2'b00}, NOP, '{1,1,16'h3333,0,0}, NX, 1'b0, 3'd0},
        // 6: B writes, A reads address 4 (R5)
        '{'{1,0,4'd4,16'h0,2'b00}, '{1,1,4'd4,16'h4444,2'b00}, NX, NX, 1'b0, 3'd3},
        // 7: read back address 4 (R6)
        '{NOP, '{1,0,4'd4,16'h0,2'b00}, NX, '{1,1,16'h4444,0,0}, 1'b0, 3'd0},
        // 8: both write address 5 (R7)
        '{'{1,1,4'd5,16'h5555,2'b00}, '{1,1,4'd5,16'h5AAA,2'b00}, NX, NX, 1'b1, 3'd4},
        // 9: port A's word kept (R7)
        '{NOP, '{1,0,4'd5,16'h0,2'b00}, NX, '{1,1,16'h5555,0,0}, 1'b0, 3'd0},
        // 10: single-flip writes (R8)
        '{'{1,1,4'd6,16'h6666,2'b01}, '{1,1,4'd7,16'h7777,2'b10}, NX, NX, 1'b0, 3'd0},
        // 11: corrected reads (R8)
        '{'{1,0,4'd7,16'h0,2'b00}, '{1,0,4'd6,16'h0,2'b00},
          '{1,1,16'h7777,1,0}, '{1,1,16'h6666,1,0}, 1'b0, 3'd0},
        // 12: double-flip write (R9)
        '{'{1,1,4'd8,16'h8888,2'b11}, NOP, NX, NX, 1'b0, 3'd0},
        // 13: double detected (R9)
        '{'{1,0,4'd8,16'h0,2'b00}, '{1,0,4'd1,16'h0,2'b00},
          '{1,0,16'h0,0,1}, '{1,1,16'h1111,0,0}, 1'b0, 3'd0},
        // 14: equal address, B disabled: no collision (R3)
        '{'{1,0,4'd2,16'h0,2'b00}, '{0,1,4'd2,16'hDEAD,2'b00},
          '{1,1,16'h2222,0,0}, NX, 1'b0, 3'd0},
        // 15: crossing over a double-flipped word: flags masked (R5)
        '{'{1,1,4'd8,16'h0808,2'b00}, '{1,0,4'd8,16'h0,2'b00}, NX, NX, 1'b0, 3'd2},
        // 16: clean read back (R6)
        '{NOP, '{1,0,4'd8,16'h0,2'b00}, NX, '{1,1,16'h0808,0,0}, 1'b0, 3'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_en = 0, a_we = 0, b_en = 0, b_we = 0;
    logic [3:0]  a_addr = '0, b_addr = '0;
    logic [15:0] a_wdata = '0, b_wdata = '0;
    logic [1:0]  a_inj = '0, b_inj = '0;
    logic [15:0] a_rdata, b_rdata;
    logic        a_rvalid, a_corr, a_dbl, b_rvalid, b_corr, b_dbl, ww_conflict;
    logic [2:0]  coll_code;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dpram_ecc_guard uut (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_inj(a_inj),
        .a_rdata(a_rdata), .a_rvalid(a_rvalid), .a_corr(a_corr), .a_dbl(a_dbl),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_inj(b_inj),
        .b_rdata(b_rdata), .b_rvalid(b_rvalid), .b_corr(b_corr), .b_dbl(b_dbl),
        .ww_conflict(ww_conflict), .coll_code(coll_code)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input op_t a, input op_t b);
        a_en = a.en; a_we = a.we; a_addr = a.addr; a_wdata = a.data; a_inj = a.inj;
        b_en = b.en; b_we = b.we; b_addr = b.addr; b_wdata = b.data; b_inj = b.inj;
    endtask

    task automatic check_idle_flags(input string req);
        check(req, "a_rvalid", 32'(a_rvalid), 0);
        check(req, "b_rvalid", 32'(b_rvalid), 0);
        check(req, "a_corr|a_dbl", 32'(a_corr | a_dbl), 0);
        check(req, "b_corr|b_dbl", 32'(b_corr | b_dbl), 0);
        check(req, "ww_conflict", 32'(ww_conflict), 0);
        check(req, "coll_code", 32'(coll_code), 0);
    endtask

    initial begin
        #1500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle_flags("R1");                        // R1 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].a, VEC[i].b);
            @(negedge clk);
            check("R3", $sformatf("v%0d coll_code", i), 32'(coll_code), 32'(VEC[i].code));
            check("R7", $sformatf("v%0d ww_conflict", i), 32'(ww_conflict), 32'(VEC[i].ww));
            check("R10", $sformatf("v%0d a_rvalid", i), 32'(a_rvalid), 32'(VEC[i].ea.v));
            check("R10", $sformatf("v%0d b_rvalid", i), 32'(b_rvalid), 32'(VEC[i].eb.v));
            check("R8", $sformatf("v%0d a_corr", i), 32'(a_corr), 32'(VEC[i].ea.corr));
            check("R8", $sformatf("v%0d b_corr", i), 32'(b_corr), 32'(VEC[i].eb.corr));
            check("R9", $sformatf("v%0d a_dbl", i), 32'(a_dbl), 32'(VEC[i].ea.dbl));
            check("R9", $sformatf("v%0d b_dbl", i), 32'(b_dbl), 32'(VEC[i].eb.dbl));
            if (VEC[i].ea.chk)
                check("R2", $sformatf("v%0d a_rdata", i), 32'(a_rdata), 32'(VEC[i].ea.data));
            if (VEC[i].eb.chk)
                check("R11", $sformatf("v%0d b_rdata", i), 32'(b_rdata), 32'(VEC[i].eb.data));
        end

        // R3: different addresses with one write do not collide
        drive('{1,0,4'd1,16'h0,2'b00}, '{1,1,4'd2,16'h2BBB,2'b00});
        @(negedge clk);
        check("R3", "distinct rw coll_code", 32'(coll_code), 0);
        check("R3", "distinct rw a_rvalid", 32'(a_rvalid), 1);
        check("R3", "distinct rw a_rdata", 32'(a_rdata), 32'h1111);

        // R11: B reads while A writes: old word 16'h2BBB presented, not valid
        drive('{1,1,4'd2,16'h2CCC,2'b00}, '{1,0,4'd2,16'h0,2'b00});
        @(negedge clk);
        check("R11", "collide b_rdata", 32'(b_rdata), 32'h2BBB);
        check("R5", "collide b_rvalid", 32'(b_rvalid), 0);

        // R1: asynchronous reset in the middle of a valid read pair
        drive('{1,0,4'd2,16'h0,2'b00}, '{1,0,4'd2,16'h0,2'b00});
        @(negedge clk);
        check("R4", "pair a_rdata", 32'(a_rdata), 32'h2CCC);
        check("R4", "pair code", 32'(coll_code), 1);
        drive(NOP, NOP);
        rst_n = 1'b0;
        #1;
        check_idle_flags("R1");
        @(negedge clk);
        rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule